// File: doc/BRIEF.md
# Bus Activity Monitor

The block watches memory traffic on several independent channels. Each channel adds a programmable weight to a period accumulator for every event pulse it sees. A shared timer counts millisecond ticks and marks the end of each sampling period. At that point every running channel takes the accumulated sum as its sample, clears the accumulator, and folds the sample into an exponential moving average.

The channel then tests the raw sample against an upper and a lower watermark. It raises a flag only after a programmed number of successive samples breach the same watermark. It also tests the new average against a second pair of watermarks. The flags collect in a per-channel status register that is cleared by writing ones. The enabled flags of all channels are ORed into one interrupt line. Software reaches all of this through a 32-bit register port with a combinational read path.

Each channel is sequenced by a four-state machine:
- CH_OFF: the channel is stopped and holds its accumulator and run counters at zero.
- CH_RUN: the channel accumulates events.
- CH_AVG: the channel updates the average.
- CH_CMP: the channel evaluates the watermarks.

The transitions are:
- OFF→RUN, once the enable bit and the periodic bit are both set.
- RUN→AVG, on the period strobe.
- AVG→CMP, unconditionally.
- CMP→RUN, unconditionally.
- Any state→OFF, as soon as either enable bit is cleared.

Top module: `bus_activity_monitor`

## Requirements
- R1: The global period register sits at byte address 0x004, bits 7:0, and holds P. A sample is taken on every (P+1)-th `ms_tick`, so a period spans 1 to 256 ms. Channel c occupies the block at 0x40·(c+1).
- R2: While a channel runs, each cycle with its event pulse high adds the count weight (offset 0x18) to the accumulator, saturating at all ones. The sample is the accumulator value at the period end, and the accumulator restarts from zero for the next period.
- R3: At each period end the average (read at offset 0x20) becomes avg + ((sample − avg) >>> (K+1)). The shift is an arithmetic shift of the signed difference, and K is control bits 12:10, so the window is 2^(K+1) samples. Writing offset 0x0C loads the average directly.
- R4: With control bit 30 set, status bit 31 is set after N successive samples strictly above the upper watermark (offset 0x04). N−1 is held in control bits 28:26. The run counter restarts after any non-breaching sample and after the flag is raised.
- R5: With control bit 29 set, status bit 30 is set after M successive samples strictly below the lower watermark (offset 0x08). M−1 is held in control bits 25:23. The same restart rules as R4 apply.
- R6: With control bit 21 set, status bit 29 is set when the updated average is strictly above offset 0x10. With control bit 20 set, status bit 28 is set when the updated average is strictly below offset 0x14.
- R7: The status register (offset 0x24) clears each bit written as one. Writing all ones clears every flag.
- R8: A channel is pending when any of its status bits 31..28 is set while the matching enable (control bit 30, 29, 21 or 20) and control bit 31 are set. `irq` is the OR of all pending channels, and the global register at 0x000 shows channel c's pending state in bit c.
- R9: A channel samples only while control bits 31 and 18 are both set. Writing zero to control stops it: further events and ticks leave its average and status untouched, and the channel no longer drives `irq`.
- R10: After reset every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_pulse | input | NUM_CH | One event pulse per channel |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| irq | output | 1 | Combined interrupt |

## Verification
Channel 0 is driven with a sequence of per-period event counts:
- Runs of high counts check that the upper run length fires at exactly N and then restarts.
- Runs of low counts do the same for the lower run length.
- A lone middle sample between low samples shows that a broken run restarts its counter.

The same sequence walks the average up and down. This covers the rounding of negative differences by the arithmetic shift and the crossings of both average watermarks.

Directed cases cover the remaining behaviour:
- A longer period and a wider window tell the period count apart from the shift amount.
- A stopped channel receives traffic, to show it ignores it.
- A second channel with another weight separates the per-channel pending bits and the enable gating of `irq` from the status flags themselves.

// File: rtl/actmon_pkg.sv
package actmon_pkg;

    typedef enum logic [1:0] {
        CH_OFF = 2'd0,
        CH_RUN = 2'd1,
        CH_AVG = 2'd2,
        CH_CMP = 2'd3
    } ch_state_e;

    // channel-relative byte offsets
    localparam logic [5:0] OFF_CTRL    = 6'h00;
    localparam logic [5:0] OFF_UP_WM   = 6'h04;
    localparam logic [5:0] OFF_LO_WM   = 6'h08;
    localparam logic [5:0] OFF_SEED    = 6'h0C;
    localparam logic [5:0] OFF_AVG_UP  = 6'h10;
    localparam logic [5:0] OFF_AVG_LO  = 6'h14;
    localparam logic [5:0] OFF_WEIGHT  = 6'h18;
    localparam logic [5:0] OFF_AVG     = 6'h20;
    localparam logic [5:0] OFF_STATUS  = 6'h24;

    // control bit positions
    localparam int CB_RUN      = 31;
    localparam int CB_UP_EN    = 30;
    localparam int CB_DN_EN    = 29;
    localparam int CB_UPLEN_LO = 26;
    localparam int CB_DNLEN_LO = 23;
    localparam int CB_AHI_EN   = 21;
    localparam int CB_ALO_EN   = 20;
    localparam int CB_PERIODIC = 18;
    localparam int CB_K_LO     = 10;
    localparam int LEN_W       = 3;
    localparam int K_W         = 3;

    // status bit positions
    localparam int SB_UP  = 31;
    localparam int SB_DN  = 30;
    localparam int SB_AHI = 29;
    localparam int SB_ALO = 28;

endpackage

// File: rtl/actmon_period_timer.sv
module actmon_period_timer #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period,
    input  logic          tick,
    output logic          strobe
);

    logic [PW-1:0] tick_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            strobe   <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (tick) begin
                if (tick_cnt >= period) begin
                    tick_cnt <= '0;
                    strobe   <= 1'b1;
                end else begin
                    tick_cnt <= tick_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/actmon_channel.sv
module actmon_channel
    import actmon_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          ev,
    input  logic          strobe,
    output logic          pending,
    output logic          cmp_phase,
    output logic          avg_phase,
    output logic [DW-1:0] avg_out
);

    localparam int CW = LEN_W + 1;
    localparam int SW = K_W + 1;

    ch_state_e state, state_nx;

    logic [DW-1:0] ctrl, up_wm, lo_wm, avg_hi, avg_lo, weight;
    logic [DW-1:0] avg, acc, sample, status;
    logic [CW-1:0] up_cnt, dn_cnt;

    logic          run_ok;
    logic [DW:0]   acc_sum;
    logic signed [DW:0] diff, step;
    logic [SW-1:0] shamt;
    logic [DW-1:0] avg_new;
    logic [CW-1:0] up_need, dn_need;
    logic          up_hit, dn_hit, up_fire, dn_fire;
    logic [DW-1:0] set_vec, clr_vec, gate_vec;

    assign run_ok = ctrl[CB_RUN] & ctrl[CB_PERIODIC];

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!run_ok) begin
            state_nx = CH_OFF;
        end else begin
            unique case (state)
                CH_OFF: state_nx = CH_RUN;
                CH_RUN: state_nx = strobe ? CH_AVG : CH_RUN;
                CH_AVG: state_nx = CH_CMP;
                CH_CMP: state_nx = CH_RUN;
                default: state_nx = CH_OFF;
            endcase
        end
    end

    // ---------------- state outputs ----------------
    always_comb begin
        cmp_phase = 1'b0;
        avg_phase = 1'b0;
        unique case (state)
            CH_OFF: ;
            CH_RUN: ;
            CH_AVG: avg_phase = 1'b1;
            CH_CMP: cmp_phase = 1'b1;
            default: ;
        endcase
    end

    // ---------------- datapath ----------------
    assign acc_sum = {1'b0, acc} + {1'b0, weight};
    assign shamt   = SW'(ctrl[CB_K_LO +: K_W]) + SW'(1);
    assign diff    = $signed({1'b0, sample}) - $signed({1'b0, avg});
    assign step    = diff >>> shamt;
    assign avg_new = avg + step[DW-1:0];

    assign up_need = CW'(ctrl[CB_UPLEN_LO +: LEN_W]) + CW'(1);
    assign dn_need = CW'(ctrl[CB_DNLEN_LO +: LEN_W]) + CW'(1);
    assign up_hit  = ctrl[CB_UP_EN] && (sample > up_wm);
    assign dn_hit  = ctrl[CB_DN_EN] && (sample < lo_wm);
    assign up_fire = up_hit && ((up_cnt + 1'b1) == up_need);
    assign dn_fire = dn_hit && ((dn_cnt + 1'b1) == dn_need);

    always_comb begin
        set_vec = '0;
        if (cmp_phase) begin
            set_vec[SB_UP]  = up_fire;
            set_vec[SB_DN]  = dn_fire;
            set_vec[SB_AHI] = ctrl[CB_AHI_EN] && (avg > avg_hi);
            set_vec[SB_ALO] = ctrl[CB_ALO_EN] && (avg < avg_lo);
        end
        clr_vec = (wr_en && addr == OFF_STATUS) ? wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            up_wm  <= '0;
            lo_wm  <= '0;
            avg_hi <= '0;
            avg_lo <= '0;
            weight <= '0;
            avg    <= '0;
            acc    <= '0;
            sample <= '0;
            status <= '0;
            up_cnt <= '0;
            dn_cnt <= '0;
        end else begin
            if (wr_en) begin
                unique case (addr)
                    OFF_CTRL:   ctrl   <= wdata;
                    OFF_UP_WM:  up_wm  <= wdata;
                    OFF_LO_WM:  lo_wm  <= wdata;
                    OFF_AVG_UP: avg_hi <= wdata;
                    OFF_AVG_LO: avg_lo <= wdata;
                    OFF_WEIGHT: weight <= wdata;
                    default: ;
                endcase
            end

            // accumulator and sample capture
            if (state == CH_OFF || !run_ok) begin
                acc <= '0;
            end else if (state == CH_RUN && strobe) begin
                sample <= acc;
                acc    <= ev ? weight : '0;
            end else if (ev) begin
                acc <= acc_sum[DW] ? '1 : acc_sum[DW-1:0];
            end

            // average: a seed write wins over the update
            if (wr_en && addr == OFF_SEED) avg <= wdata;
            else if (avg_phase)            avg <= avg_new;

            // run counters
            if (state == CH_OFF) begin
                up_cnt <= '0;
                dn_cnt <= '0;
            end else if (cmp_phase) begin
                up_cnt <= (up_hit && !up_fire) ? up_cnt + 1'b1 : '0;
                dn_cnt <= (dn_hit && !dn_fire) ? dn_cnt + 1'b1 : '0;
            end

            status <= (status & ~clr_vec) | set_vec;
        end
    end

    always_comb begin
        gate_vec         = '0;
        gate_vec[SB_UP]  = ctrl[CB_UP_EN];
        gate_vec[SB_DN]  = ctrl[CB_DN_EN];
        gate_vec[SB_AHI] = ctrl[CB_AHI_EN];
        gate_vec[SB_ALO] = ctrl[CB_ALO_EN];
    end

    assign pending = ctrl[CB_RUN] && |(status & gate_vec);
    assign avg_out = avg;

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_CTRL:   rdata = ctrl;
            OFF_UP_WM:  rdata = up_wm;
            OFF_LO_WM:  rdata = lo_wm;
            OFF_SEED:   rdata = avg;
            OFF_AVG_UP: rdata = avg_hi;
            OFF_AVG_LO: rdata = avg_lo;
            OFF_WEIGHT: rdata = weight;
            OFF_AVG:    rdata = avg;
            OFF_STATUS: rdata = status;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/bus_activity_monitor.sv
module bus_activity_monitor #(
    parameter int NUM_CH = 2,
    parameter int DW     = 32,
    parameter int AW     = 12,
    parameter int PW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NUM_CH-1:0] ev_pulse,
    input  logic              ms_tick,
    output logic              irq
);

    localparam int OFS_W = 6;
    localparam int BLK_W = AW - OFS_W;
    localparam logic [OFS_W-1:0] G_STATUS = 6'h00;
    localparam logic [OFS_W-1:0] G_PERIOD = 6'h04;

    logic [BLK_W-1:0] blk;
    logic [OFS_W-1:0] ofs;
    logic [PW-1:0]    period_q;
    logic             tick_strobe;
    logic [NUM_CH-1:0] ch_pend, ch_cmp, ch_avgph;
    logic [DW-1:0]    ch_rdata [NUM_CH];
    logic [DW-1:0]    ch_avg   [NUM_CH];

    assign blk = reg_addr[AW-1:OFS_W];
    assign ofs = reg_addr[OFS_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                        period_q <= '0;
        else if (reg_we && blk == '0 && ofs == G_PERIOD)   period_q <= reg_wdata[PW-1:0];
    end

    actmon_period_timer #(.PW(PW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period_q),
        .tick   (ms_tick),
        .strobe (tick_strobe)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [BLK_W-1:0] MY_BLK = BLK_W'(c + 1);
        actmon_channel #(.DW(DW), .AW(OFS_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_we && blk == MY_BLK),
            .addr      (ofs),
            .wdata     (reg_wdata),
            .rdata     (ch_rdata[c]),
            .ev        (ev_pulse[c]),
            .strobe    (tick_strobe),
            .pending   (ch_pend[c]),
            .cmp_phase (ch_cmp[c]),
            .avg_phase (ch_avgph[c]),
            .avg_out   (ch_avg[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (blk == '0) begin
            if (ofs == G_STATUS)      reg_rdata = DW'(ch_pend);
            else if (ofs == G_PERIOD) reg_rdata = DW'(period_q);
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (blk == BLK_W'(c + 1)) reg_rdata = ch_rdata[c];
            end
        end
    end

    assign irq = |ch_pend;

endmodule

// File: rtl/actmon_checker.sv
module actmon_checker #(
    parameter int NUM_CH = 2,
    parameter int DW     = 32,
    parameter int AW     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [AW-1:0]     reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              ms_tick,
    input logic              irq,
    input logic              strobe,
    input logic [NUM_CH-1:0] cmp_phase,
    input logic [NUM_CH-1:0] pend,
    input logic [DW-1:0]     avg_ch0,
    input logic              avg_phase0
);

    localparam logic [AW-1:0] CH0_CTRL = AW'(12'h040);
    localparam logic [AW-1:0] CH0_SEED = AW'(12'h04C);

    // R1: a period end only follows a millisecond tick
    p_strobe_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(ms_tick));

    // R3: the average moves only in its update phase or on a seed write
    p_avg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(avg_phase0) && !$past(reg_we && reg_addr == CH0_SEED)) |-> $stable(avg_ch0));

    // R8: the interrupt rises only after a compare phase or a register write
    p_irq_rise_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|cmp_phase) || $past(reg_we)));

    // R9: stopping a channel withdraws its pending state
    p_stop_clears_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == CH0_CTRL && reg_wdata == '0) |=> !pend[0]);

endmodule

bind bus_activity_monitor actmon_checker #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ms_tick    (ms_tick),
    .irq        (irq),
    .strobe     (tick_strobe),
    .cmp_phase  (ch_cmp),
    .pend       (ch_pend),
    .avg_ch0    (ch_avg[0]),
    .avg_phase0 (ch_avgph[0])
);

// File: tb/sim_bus_activity_monitor.sv
`timescale 1ns/1ps
module sim_bus_activity_monitor;

    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] ev_pulse = '0;
    logic        ms_tick = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    bus_activity_monitor #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse),
        .ms_tick(ms_tick), .irq(irq)
    );

    // channel 0 at 0x040, channel 1 at 0x080
    localparam logic [11:0] A_GSTAT = 12'h000, A_PER = 12'h004;
    localparam logic [11:0] C0 = 12'h040, C1 = 12'h080;
    localparam logic [11:0] O_CTRL = 12'h00, O_UP = 12'h04, O_LO = 12'h08, O_SEED = 12'h0C,
                            O_AUP = 12'h10, O_ALO = 12'h14, O_WT = 12'h18, O_AVG = 12'h20,
                            O_ST = 12'h24;

    // per-period event counts and expected average / status (weight 4, K=0)
    localparam int ROWS = 14;
    localparam int          V_EV  [ROWS] = '{15, 15, 20, 20, 2, 2, 2, 0, 10, 0, 10, 0, 0, 0};
    localparam logic [31:0] V_AVG [ROWS] = '{50, 55, 67, 73, 40, 24, 16, 8, 24, 12, 26, 13, 6, 3};
    localparam logic [31:0] V_ST  [ROWS] = '{32'h0, 32'h8000_0000, 32'h2000_0000, 32'hA000_0000,
                                             32'h0, 32'h0, 32'h4000_0000, 32'h1000_0000,
                                             32'h0, 32'h0, 32'h0, 32'h0, 32'h1000_0000,
                                             32'h5000_0000};

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic events(input int ch, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ev_pulse[ch] = 1'b1;
            @(negedge clk); ev_pulse[ch] = 1'b0;
        end
    endtask

    task automatic tick();
        @(negedge clk); ms_tick = 1'b1;
        @(negedge clk); ms_tick = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        rd(C0 + O_CTRL, v); chk("R10 ctrl", v, 0);
        rd(C0 + O_AVG, v);  chk("R10 avg", v, 0);
        rd(A_PER, v);       chk("R10 period", v, 0);
        rd(A_GSTAT, v);     chk("R10 gstat", v, 0);
        chk("R10 irq", {31'b0, irq}, 0);

        // table walk on channel 0
        wr(A_PER, 0);
        wr(C0 + O_WT, 4);
        wr(C0 + O_UP, 50);
        wr(C0 + O_LO, 20);
        wr(C0 + O_AUP, 60);
        wr(C0 + O_ALO, 10);
        wr(C0 + O_SEED, 40);
        wr(C0 + O_CTRL, 32'hE534_0000);
        for (int r = 0; r < ROWS; r++) begin
            events(0, V_EV[r]);
            tick();
            rd(C0 + O_AVG, v);  chk("R2 R3 avg", v, V_AVG[r]);
            rd(C0 + O_ST, v);   chk("R4 R5 R6 status", v, V_ST[r]);
            rd(A_GSTAT, v);     chk("R8 gstat", v, (V_ST[r] != 0) ? 1 : 0);
            chk("R8 irq", {31'b0, irq}, (V_ST[r] != 0) ? 1 : 0);
            wr(C0 + O_ST, 32'hFFFF_FFFF);
            rd(C0 + O_ST, v);   chk("R7 clear all", v, 0);
        end

        // R1 + R3: period of 3 ticks, window 8
        wr(C0 + O_CTRL, 32'h8004_0800);
        wr(C0 + O_SEED, 0);
        wr(A_PER, 2);
        events(0, 20);
        tick();
        rd(C0 + O_AVG, v); chk("R1 tick1 no sample", v, 0);
        tick();
        rd(C0 + O_AVG, v); chk("R1 tick2 no sample", v, 0);
        tick();
        rd(C0 + O_AVG, v); chk("R1 R3 tick3 sample K=2", v, 10);
        // R2: accumulator restarted, empty period
        tick(); tick(); tick();
        rd(C0 + O_AVG, v); chk("R2 accumulator cleared", v, 8);

        // R9: stop channel 0, seed idle channel 1
        wr(C0 + O_CTRL, 0);
        wr(C1 + O_SEED, 100);
        wr(A_PER, 0);
        events(0, 5);
        events(1, 5);
        tick();
        rd(C0 + O_AVG, v); chk("R9 ch0 stopped avg", v, 8);
        rd(C1 + O_AVG, v); chk("R9 ch1 idle avg", v, 100);
        rd(C1 + O_ST, v);  chk("R9 ch1 idle status", v, 0);
        chk("R9 irq idle", {31'b0, irq}, 0);

        // R2 + R4 + R8 on channel 1: weight 7, run length 1
        wr(C1 + O_WT, 7);
        wr(C1 + O_UP, 5);
        wr(C1 + O_SEED, 0);
        wr(C1 + O_CTRL, 32'hC004_0000);
        events(1, 3);
        tick();
        rd(C1 + O_AVG, v); chk("R2 weight 7 avg", v, 10);
        rd(C1 + O_ST, v);  chk("R4 run of one", v, 32'h8000_0000);
        rd(A_GSTAT, v);    chk("R8 channel1 bit", v, 2);
        chk("R8 irq set", {31'b0, irq}, 1);
        // R8: enable gating keeps the flag but drops irq
        wr(C1 + O_CTRL, 32'h8004_0000);
        chk("R8 gated irq", {31'b0, irq}, 0);
        rd(C1 + O_ST, v);  chk("R8 flag kept", v, 32'h8000_0000);
        // R7: writing a zero bit keeps it, a one bit clears it
        wr(C1 + O_ST, 32'h4000_0000);
        rd(C1 + O_ST, v);  chk("R7 partial write", v, 32'h8000_0000);
        wr(C1 + O_ST, 32'h8000_0000);
        rd(C1 + O_ST, v);  chk("R7 bit clear", v, 0);

        summary();
    end

endmodule